// File: doc/BRIEF.md
# Multi-Mode DDS Phase Core

This block is the phase engine of a direct digital synthesizer. A 48-bit phase accumulator advances once per clock by the active tuning word. A 3-bit mode input decides how that word is produced: taken as is, chosen by a control pin, ramped linearly between two words, or swept without limit as a chirp. A 14-bit phase offset is added after the accumulator, and the top 17 bits of the result go to an external sine/cosine lookup.

The same control pin has a different meaning in each mode. In FSK it picks the tuning word. In ramped FSK it picks the ramp target. In chirp mode it freezes the sweep. In BPSK it picks the phase offset. Two phase outputs are produced, one for the cosine (I) channel and one for the sine (Q) channel, a fixed quarter turn apart. All words come from a register bank that has already been updated, and the block holds them only as inputs.

Top module: `dds_phase_core`

## Requirements
- R1: While reset is active, and after reset while every word input is zero, `phase_q_o` is 0 and `phase_i_o` is 0x08000 (a quarter turn), so the output is 0 Hz at zero phase.
- R2: The accumulator advances by the active tuning word once per clock. `phase_q_o` is accumulator bits [47:31] plus the phase offset shifted left by 3. A change of tuning word on the inputs shows in the per-cycle phase step on the third output sample after the clock edge that captures it.
- R3: `mode_i` 000 (single tone) and the unused codes 101, 110 and 111 use tuning word 1. In these modes the control pin, tuning word 2 and offset 2 have no effect.
- R4: With `mode_i` 001 (FSK), the active word is tuning word 1 when the control pin is low and tuning word 2 when it is high.
- R5: With `mode_i` 010 (ramped FSK), entering the mode loads tuning word 1. After that the active word moves by the delta word once every `rate_i`+1 clocks, and the first step falls `rate_i`+1 clocks after entry.
- R6: In ramped FSK the target is word 2 when the pin is high and word 1 when it is low. The ramp stops exactly at the target and never passes it, and when the pin reverses it runs back toward the other word.
- R7: With `mode_i` 011 (chirp), entering the mode loads tuning word 1. The delta word is then added once every `rate_i`+1 clocks, with no bound.
- R8: In chirp mode a high control pin freezes the active word and the rate timer. When the pin goes low the sweep continues.
- R9: With `mode_i` 100 (BPSK), the pin selects offset 1 when low and offset 2 when high, while tuning word 1 sets the frequency. An offset change shows on the output on the second sample after the capturing edge.
- R10: A change of frequency or mode never clears the accumulator, so the phase stays continuous.
- R11: `phase_i_o` minus `phase_q_o` is always 0x08000 modulo 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| ctl_pin_i | input | 1 | Shared control pin: frequency select, ramp target, sweep hold, or phase select |
| ftw1_i | input | 48 | Tuning word 1 |
| ftw2_i | input | 48 | Tuning word 2 |
| dfw_i | input | 48 | Delta frequency word for ramp and chirp |
| rate_i | input | 16 | Clocks per ramp step, minus one |
| poff1_i | input | 14 | Phase offset 1 |
| poff2_i | input | 14 | Phase offset 2 |
| phase_i_o | output | 17 | Truncated phase for the cosine lookup |
| phase_q_o | output | 17 | Truncated phase for the sine lookup |

## Verification
A tuning word moves through three registers on its way to the output: the active word, the accumulator and the output stage. The bench therefore takes the phase difference between consecutive samples and expects a new word on the third sample after the capturing edge. An offset passes through only two registers, so it is expected on the second sample. Ramp and chirp sequences are checked sample by sample against a model of step times written from R5 and R7, with the first step `rate_i`+1 clocks after entry. Every input is driven and every output is sampled on the falling edge, so each expected sample falls at a fixed edge count.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [2:0] {
    MODE_TONE  = 3'b000,
    MODE_FSK   = 3'b001,
    MODE_RFSK  = 3'b010,
    MODE_CHIRP = 3'b011,
    MODE_BPSK  = 3'b100
  } dds_mode_e;
endpackage

// File: rtl/dds_rate_timer.sv
module dds_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // >= so that lowering the rate mid-count never waits for a wrap
  assign tick_o = en_i && !clr_i && (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dds_freq_ctrl.sv
module dds_freq_ctrl
  import dds_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              pin_i,
  input  logic [ACC_W-1:0]  ftw1_i,
  input  logic [ACC_W-1:0]  ftw2_i,
  input  logic [ACC_W-1:0]  dfw_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [ACC_W-1:0]  freq_o,
  output logic [2:0]        mode_o
);
  logic [2:0]       mode_q;
  logic             entry, tmr_en, tick;
  logic [ACC_W-1:0] freq_q, freq_d, target, step_up, step_dn, ramp_nxt, gap_dn;
  logic [ACC_W:0]   up_sum;

  assign entry  = (mode_i != mode_q);
  assign tmr_en = (mode_i == MODE_RFSK) || ((mode_i == MODE_CHIRP) && !pin_i);

  dds_rate_timer #(.RATE_W(RATE_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (entry),
    .en_i   (tmr_en),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  always_comb begin
    target  = pin_i ? ftw2_i : ftw1_i;
    up_sum  = {1'b0, freq_q} + {1'b0, dfw_i};
    step_up = (up_sum > {1'b0, target}) ? target : up_sum[ACC_W-1:0];
    gap_dn  = freq_q - target;
    step_dn = (gap_dn <= dfw_i) ? target : freq_q - dfw_i;
    if (freq_q < target)      ramp_nxt = step_up;
    else if (freq_q > target) ramp_nxt = step_dn;
    else                      ramp_nxt = freq_q;

    case (mode_i)
      MODE_FSK:   freq_d = target;
      MODE_RFSK:  freq_d = entry ? ftw1_i : (tick ? ramp_nxt : freq_q);
      MODE_CHIRP: freq_d = entry ? ftw1_i : (tick ? freq_q + dfw_i : freq_q);
      default:    freq_d = ftw1_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      mode_q <= MODE_TONE;
    end else begin
      freq_q <= freq_d;
      mode_q <= mode_i;
    end
  end

  assign freq_o = freq_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  output logic [OUT_W-1:0] acc_top_o
);
  logic [ACC_W-1:0] acc_q;

  // never cleared except by reset: frequency changes are phase continuous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + freq_i;
  end

  assign acc_top_o = acc_q[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/dds_phase_out.sv
module dds_phase_out
  import dds_pkg::*;
#(
  parameter int OUT_W  = 17,
  parameter int POFF_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              pin_i,
  input  logic [POFF_W-1:0] poff1_i,
  input  logic [POFF_W-1:0] poff2_i,
  input  logic [OUT_W-1:0]  acc_top_i,
  output logic [OUT_W-1:0]  phase_i_o,
  output logic [OUT_W-1:0]  phase_q_o
);
  localparam int              SHIFT   = OUT_W - POFF_W;
  localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

  logic [POFF_W-1:0] poff_q;
  logic [OUT_W-1:0]  poff_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) poff_q <= '0;
    else         poff_q <= ((mode_i == MODE_BPSK) && pin_i) ? poff2_i : poff1_i;
  end

  // offset is left-aligned to the accumulator MSB; below bit ACC_W-OUT_W+SHIFT it is zero
  assign poff_ext = OUT_W'(poff_q) << SHIFT;

  // channel 0: cosine (I), channel 1: sine (Q)
  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [OUT_W-1:0] CH_OFF = (c == 0) ? QUARTER : '0;
    logic [OUT_W-1:0] ph_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_r <= CH_OFF;
      else         ph_r <= acc_top_i + poff_ext + CH_OFF;
    end
  end

  assign phase_i_o = g_ch[0].ph_r;
  assign phase_q_o = g_ch[1].ph_r;
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int ACC_W  = 48,
  parameter int POFF_W = 14,
  parameter int OUT_W  = 17,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              ctl_pin_i,
  input  logic [ACC_W-1:0]  ftw1_i,
  input  logic [ACC_W-1:0]  ftw2_i,
  input  logic [ACC_W-1:0]  dfw_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [POFF_W-1:0] poff1_i,
  input  logic [POFF_W-1:0] poff2_i,
  output logic [OUT_W-1:0]  phase_i_o,
  output logic [OUT_W-1:0]  phase_q_o
);
  logic [ACC_W-1:0] act_ftw;
  logic [2:0]       mode_q;
  logic [OUT_W-1:0] acc_top;

  dds_freq_ctrl #(.ACC_W(ACC_W), .RATE_W(RATE_W)) i_freq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .pin_i  (ctl_pin_i),
    .ftw1_i (ftw1_i),
    .ftw2_i (ftw2_i),
    .dfw_i  (dfw_i),
    .rate_i (rate_i),
    .freq_o (act_ftw),
    .mode_o (mode_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .freq_i    (act_ftw),
    .acc_top_o (acc_top)
  );

  dds_phase_out #(.OUT_W(OUT_W), .POFF_W(POFF_W)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .pin_i     (ctl_pin_i),
    .poff1_i   (poff1_i),
    .poff2_i   (poff2_i),
    .acc_top_i (acc_top),
    .phase_i_o (phase_i_o),
    .phase_q_o (phase_q_o)
  );
endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk
  import dds_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             ctl_pin_i,
  input logic [ACC_W-1:0] ftw1_i,
  input logic [ACC_W-1:0] ftw2_i,
  input logic [OUT_W-1:0] phase_i_o,
  input logic [OUT_W-1:0] phase_q_o,
  input logic [ACC_W-1:0] act_ftw,
  input logic [2:0]       mode_q
);
  localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

  logic [OUT_W-1:0] qdiff;
  logic [ACC_W-1:0] lo, hi;
  logic             in_bounds;

  assign qdiff     = phase_i_o - phase_q_o;
  assign lo        = (ftw1_i < ftw2_i) ? ftw1_i : ftw2_i;
  assign hi        = (ftw1_i < ftw2_i) ? ftw2_i : ftw1_i;
  assign in_bounds = (act_ftw >= lo) && (act_ftw <= hi);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (phase_q_o == '0 && phase_i_o == QUARTER);
    end
  end

  p_tone_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TONE) |=> (act_ftw == $past(ftw1_i)));

  p_fsk_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FSK) |=> (act_ftw == ($past(ctl_pin_i) ? $past(ftw2_i) : $past(ftw1_i))));

  p_ramp_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RFSK && mode_q == MODE_RFSK && in_bounds)
    |=> (act_ftw >= $past(lo) && act_ftw <= $past(hi)));

  p_chirp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CHIRP && mode_q == MODE_CHIRP && ctl_pin_i) |=> $stable(act_ftw));

  p_quadrature_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qdiff == QUARTER);
endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .ctl_pin_i (ctl_pin_i),
  .ftw1_i    (ftw1_i),
  .ftw2_i    (ftw2_i),
  .phase_i_o (phase_i_o),
  .phase_q_o (phase_q_o),
  .act_ftw   (act_ftw),
  .mode_q    (mode_q)
);

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'b000;
  logic        ctl_pin_i = 1'b0;
  logic [47:0] ftw1_i = '0, ftw2_i = '0, dfw_i = '0;
  logic [15:0] rate_i = '0;
  logic [13:0] poff1_i = '0, poff2_i = '0;
  logic [16:0] phase_i_o, phase_q_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] prev_ph = '0, cur_ph = '0, delta = '0;

  always #4 clk_i = ~clk_i;

  dds_phase_core i_dds_phase_core (.*);

  function automatic logic [47:0] ku(int k);
    return 48'(k) << 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    prev_ph = cur_ph;
    cur_ph  = phase_q_o;
    delta   = cur_ph - prev_ph;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int rfsk_f(int j);
    if (j < 4)  return 10;
    if (j < 8)  return 14;
    if (j < 12) return 18;
    return 20;
  endfunction

  function automatic int chirp_f(int j);
    if (j < 0) return 10;
    return 5 + 2 * (j / 2);
  endfunction

  task automatic t_reset();
    settle(2);
    check("R1 reset q", 32'(phase_q_o), 0);
    check("R1 reset i", 32'(phase_i_o), 32'h8000);
    rst_ni = 1'b1;
    settle(4);
    check("R1 post-reset q", 32'(phase_q_o), 0);
    check("R1 post-reset i", 32'(phase_i_o), 32'h8000);
    check("R1 zero step", 32'(delta), 0);
  endtask

  task automatic t_tone();
    mode_i = 3'b000; ftw1_i = ku(7); ftw2_i = ku(13); poff2_i = 14'h1000;
    settle(4);
    for (int i = 0; i < 6; i++) begin
      ctl_pin_i = ~ctl_pin_i;
      step();
      check("R3 tone ignores pin/word2/offset2", 32'(delta), 7);
    end
    mode_i = 3'b111; ctl_pin_i = 1'b1;
    settle(4);
    check("R3 undefined mode uses word1", 32'(delta), 7);
    check("R11 quadrature", 32'(17'(phase_i_o - phase_q_o)), 32'h8000);
  endtask

  task automatic t_fsk();
    mode_i = 3'b001; ftw1_i = ku(3); ftw2_i = ku(9); ctl_pin_i = 1'b0; poff2_i = '0;
    settle(5);
    check("R4 fsk low", 32'(delta), 3);
    ctl_pin_i = 1'b1;
    step(); check("R2 latency sample1", 32'(delta), 3);
    step(); check("R2 latency sample2", 32'(delta), 3);
    step(); check("R4 R10 fsk high continuous", 32'(delta), 9);
    ctl_pin_i = 1'b0;
    settle(4);
    check("R4 fsk back low", 32'(delta), 3);
  endtask

  task automatic t_rfsk();
    int lo_seen;
    mode_i = 3'b000; ftw1_i = ku(10);
    settle(4);
    rate_i = 16'd3; dfw_i = ku(4); ftw2_i = ku(20); mode_i = 3'b010; ctl_pin_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      check($sformatf("R5 R6 ramp up sample %0d", i), 32'(delta), 32'(rfsk_f(i - 2)));
    end
    ctl_pin_i = 1'b0;
    lo_seen = 20;
    for (int i = 0; i < 40; i++) begin
      step();
      if (int'(delta) < lo_seen) lo_seen = int'(delta);
    end
    check("R6 ramp down no overshoot", 32'(lo_seen), 10);
    check("R6 ramp down reaches word1", 32'(delta), 10);
  endtask

  task automatic t_chirp();
    int first;
    ftw1_i = ku(5); dfw_i = ku(2); rate_i = 16'd1; ctl_pin_i = 1'b0; mode_i = 3'b011;
    for (int i = 0; i < 12; i++) begin
      step();
      check($sformatf("R7 chirp sample %0d", i), 32'(delta), 32'(chirp_f(i - 2)));
    end
    ctl_pin_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      check("R8 chirp hold frozen", 32'(delta), 15);
    end
    first = int'(delta);
    ctl_pin_i = 1'b0;
    settle(8);
    check("R8 chirp resumes", 32'(int'(delta) > first), 1);
  endtask

  task automatic t_bpsk();
    logic [16:0] p0;
    mode_i = 3'b100; ftw1_i = '0; poff1_i = 14'h0100; poff2_i = 14'h2100; ctl_pin_i = 1'b0;
    settle(5);
    check("R9 bpsk zero frequency", 32'(delta), 0);
    p0 = cur_ph;
    ctl_pin_i = 1'b1;
    step(); check("R9 offset not yet", 32'(cur_ph), 32'(p0));
    step(); check("R9 offset2 applied", 32'(cur_ph), 32'(17'(p0 + 17'h10000)));
    check("R11 quadrature after flip", 32'(17'(phase_i_o - phase_q_o)), 32'h8000);
    ctl_pin_i = 1'b0;
    settle(2);
    check("R9 offset1 restored", 32'(cur_ph), 32'(p0));
  endtask

  initial begin
    t_reset();
    t_tone();
    t_fsk();
    t_rfsk();
    t_chirp();
    t_bpsk();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule